// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

This block keeps elapsed time in slow-clock units for a system that sleeps most of the time. A 32.768 kHz enable strobe, synchronous to the bus clock, feeds a 16-bit down-counting prescaler. Every time the prescaler rolls over, a value counter (32 bits by default, set by `CNT_W`) steps by one and an increment event is latched. An alarm event is latched when the stepped count equals the programmed alarm value plus one. Loading the alarm register with all ones disables the alarm.

Software reaches the block through four 32-bit registers on a simple synchronous bus. The registers are mode (divisor, two interrupt enables and a restart command), alarm, value and status. Read data appears one cycle after the request. Reading status returns the two event flags and then clears them. The single level interrupt output is registered. It is high while an enabled flag is pending.

The block has no state machine. Its control is a restart strobe decoded from the bus, a prescaler rollover pulse and a clear-on-read strobe. Each of these acts in the cycle it occurs.

Top module: `rtt_alarm_timer`

## Requirements
- R1: The register select uses only `bus_addr[3:0]`: 0x0 mode, 0x4 alarm, 0x8 value, 0xC status. Any other low nibble reads as zero. `bus_rdata` is updated on the clock edge that samples a read (`bus_sel`=1, `bus_wr`=0) and is valid from the following cycle.
- R2: The mode register stores all 32 written bits and reads them back. Its fields are: bits 15:0 prescaler divisor, bit 16 alarm interrupt enable, bit 17 increment interrupt enable, bit 18 restart.
- R3: A mode write with bit 18 set clears the value counter and reloads the prescaler from bits 15:0. A divisor of 0 divides by 32768.
- R4: The prescaler advances only on cycles with `slow_tick` high. With divisor D, the value counter steps once every D such cycles, and each step sets status bit 1.
- R5: Status bit 0 is set when a step makes the value equal the alarm register plus one (modulo 2^CNT_W). It is never set while the alarm register is all ones.
- R6: `irq` is high exactly when (status bit 1 and mode bit 17) or (status bit 0 and mode bit 16). It follows a change in a flag or an enable with one register delay.
- R7: A status read returns the flags as they were before that edge and then clears both flags, which drops `irq`. An event landing on the same edge as the read is kept and is seen by the next status read.
- R8: After reset, mode reads 0x00008000, alarm reads all ones over CNT_W bits, value and status read zero, and `irq` is low. The first step comes after 32768 enabled cycles.
- R9: The alarm register reads back its stored contents. Writes to the value and status offsets change nothing.
- R10: The value counter wraps from all ones to zero. The wrap sets no flag other than status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at the slow-clock rate |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; low 4 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The counting path is run with divisors of 1, 2, 3, 4 and 0. This separates a correct terminal count from an off-by-one reload, and shows that a zero divisor is treated as 32768 and not as 65536 or 1. Alarm values placed one below, at and just past the running count show that the flag sets on alarm plus one, not on equality. A full wrap of a narrow counter with an all-ones alarm shows that the disable check and the wrap both work. Status reads issued with and without a coincident tick show whether the clear-on-read drops a new event, and the two enables are tried one at a time to show which flag reaches the interrupt.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    // register offsets (low nibble of the byte address)
    localparam logic [3:0] OFF_MODE  = 4'h0;
    localparam logic [3:0] OFF_ALARM = 4'h4;
    localparam logic [3:0] OFF_VALUE = 4'h8;
    localparam logic [3:0] OFF_STAT  = 4'hC;

    // mode register field positions
    localparam int MODE_DIV_W     = 16;
    localparam int MODE_ALM_IE    = 16;
    localparam int MODE_INC_IE    = 17;
    localparam int MODE_RESTART   = 18;

    localparam logic [31:0] MODE_RESET = 32'h0000_8000;
    localparam int          ZERO_DIV   = 32768;

    typedef enum logic [2:0] {
        REG_MODE,
        REG_ALARM,
        REG_VALUE,
        REG_STAT,
        REG_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [3:0] off);
        unique case (off)
            OFF_MODE:  return REG_MODE;
            OFF_ALARM: return REG_ALARM;
            OFF_VALUE: return REG_VALUE;
            OFF_STAT:  return REG_STAT;
            default:   return REG_NONE;
        endcase
    endfunction
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PRE_W    = 16,
    parameter int ZERO_DIV = 32768,
    parameter int RST_DIV  = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_in,
    output logic             inc_pulse
);
    localparam logic [PRE_W-1:0] ZERO_LOAD = PRE_W'(ZERO_DIV - 1);
    localparam logic [PRE_W-1:0] RST_LOAD  = PRE_W'(RST_DIV - 1);

    logic [PRE_W-1:0] reload_q;
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] new_load;

    always_comb begin
        if (div_in == '0) new_load = ZERO_LOAD;
        else              new_load = div_in - PRE_W'(1);
    end

    assign inc_pulse = tick_en && (cnt_q == '0) && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RST_LOAD;
            cnt_q    <= RST_LOAD;
        end else if (restart) begin
            reload_q <= new_load;
            cnt_q    <= new_load;
        end else if (tick_en) begin
            if (cnt_q == '0) cnt_q <= reload_q;
            else             cnt_q <= cnt_q - PRE_W'(1);
        end
    end
endmodule

// File: rtl/rtt_value_counter.sv
module rtt_value_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             inc,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] value,
    output logic             alarm_hit
);
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] target;
    logic             alarm_off;

    assign stepped   = value + CNT_W'(1);
    assign target    = alarm + CNT_W'(1);
    assign alarm_off = &alarm;
    assign alarm_hit = inc && !alarm_off && (stepped == target);

    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (restart) value <= '0;
        else if (inc)     value <= stepped;
    end
endmodule

// File: rtl/rtt_status_flags.sv
module rtt_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_evt,
    input  logic alm_evt,
    input  logic rd_clr,
    input  logic ie_inc,
    input  logic ie_alm,
    output logic flag_inc,
    output logic flag_alm,
    output logic irq
);
    logic inc_n;
    logic alm_n;

    // a read clears, but an event on the same edge survives
    always_comb begin
        inc_n = (flag_inc && !rd_clr) || inc_evt;
        alm_n = (flag_alm && !rd_clr) || alm_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_inc <= 1'b0;
            flag_alm <= 1'b0;
            irq      <= 1'b0;
        end else begin
            flag_inc <= inc_n;
            flag_alm <= alm_n;
            irq      <= (inc_n && ie_inc) || (alm_n && ie_alm);
        end
    end
endmodule

// File: rtl/rtt_alarm_timer.sv
module rtt_alarm_timer
    import rtt_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CNT_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int DW = 32;

    reg_sel_e         rsel;
    logic             wr_mode;
    logic             wr_alarm;
    logic             rd_any;
    logic             rd_stat;
    logic             restart;
    logic [DW-1:0]    mode_q;
    logic [DW-1:0]    mode_n;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] value;
    logic             inc_pulse;
    logic             alarm_hit;
    logic             flag_inc;
    logic             flag_alm;
    logic             addr_unused;

    assign addr_unused = ^bus_addr[AW-1:4];

    assign rsel     = decode_off(bus_addr[3:0]);
    assign wr_mode  = bus_sel && bus_wr && (rsel == REG_MODE);
    assign wr_alarm = bus_sel && bus_wr && (rsel == REG_ALARM);
    assign rd_any   = bus_sel && !bus_wr;
    assign rd_stat  = rd_any && (rsel == REG_STAT);
    assign restart  = wr_mode && bus_wdata[MODE_RESTART];
    assign mode_n   = wr_mode ? bus_wdata : mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RESET;
            alarm_q <= '1;
        end else begin
            mode_q <= mode_n;
            if (wr_alarm) alarm_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            unique case (rsel)
                REG_MODE:  bus_rdata <= mode_q;
                REG_ALARM: bus_rdata <= DW'(alarm_q);
                REG_VALUE: bus_rdata <= DW'(value);
                REG_STAT:  bus_rdata <= {30'd0, flag_inc, flag_alm};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    rtt_prescaler #(
        .PRE_W   (MODE_DIV_W),
        .ZERO_DIV(ZERO_DIV),
        .RST_DIV (int'(MODE_RESET[MODE_DIV_W-1:0]))
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (slow_tick),
        .restart  (restart),
        .div_in   (bus_wdata[MODE_DIV_W-1:0]),
        .inc_pulse(inc_pulse)
    );

    rtt_value_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .inc      (inc_pulse),
        .alarm    (alarm_q),
        .value    (value),
        .alarm_hit(alarm_hit)
    );

    rtt_status_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_evt (inc_pulse),
        .alm_evt (alarm_hit),
        .rd_clr  (rd_stat),
        .ie_inc  (mode_n[MODE_INC_IE]),
        .ie_alm  (mode_n[MODE_ALM_IE]),
        .flag_inc(flag_inc),
        .flag_alm(flag_alm),
        .irq     (irq)
    );
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       off,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic             inc_pulse,
    input logic             restart,
    input logic [CNT_W-1:0] value,
    input logic [CNT_W-1:0] alarm_q,
    input logic             flag_inc,
    input logic             flag_alm
);
    logic unmapped;
    assign unmapped = (off != 4'h0) && (off != 4'h4) && (off != 4'h8) && (off != 4'hC);

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && unmapped) |=> (bus_rdata == 32'd0));

    p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (value == '0));

    p_pulse_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |-> slow_tick);

    p_value_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_pulse && !restart) |=> (value == $past(value) + CNT_W'(1)));

    p_value_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_pulse && !restart) |=> $stable(value));

    p_inc_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |=> flag_inc);

    p_alarm_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&alarm_q) && !flag_alm) |=> !flag_alm);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && off == 4'hC && !inc_pulse) |=> (!flag_inc && !flag_alm && !irq));

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_inc || flag_alm));
endmodule

bind rtt_alarm_timer rtt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .off      (bus_addr[3:0]),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .inc_pulse(inc_pulse),
    .restart  (restart),
    .value    (value),
    .alarm_q  (alarm_q),
    .flag_inc (flag_inc),
    .flag_alm (flag_alm)
);

// File: tb/sim_rtt_alarm_timer.sv
module sim_rtt_alarm_timer;
    localparam int CW = 8;
    localparam logic [7:0] A_MODE = 8'h00, A_ALARM = 8'h04, A_VALUE = 8'h08, A_STAT = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    rtt_alarm_timer #(.AW(8), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb[$];

    // bench model built from the requirements
    int unsigned m_pre = 0;
    int unsigned m_div = 32768;
    logic [CW-1:0] m_vr = '0;
    logic [CW-1:0] m_ar = '1;
    logic [31:0] m_mode = 32'h8000;
    bit m_inc = 0, m_alm = 0;

    task automatic model_step();
        logic [CW-1:0] nv, tgt;
        m_pre++;
        if (m_pre == m_div) begin
            m_pre = 0;
            nv = m_vr + CW'(1);
            tgt = m_ar + CW'(1);
            m_vr = nv;
            m_inc = 1;
            if (m_ar != '1 && nv == tgt) m_alm = 1;
        end
    endtask

    // monitor: pops an expected item one cycle after each read
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual %h expected none", bus_rdata);
            end else begin
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input string tag);
        item_t it;
        @(negedge clk);
        case (a[3:0])
            4'h0: it.exp = m_mode;
            4'h4: it.exp = 32'(m_ar);
            4'h8: it.exp = 32'(m_vr);
            4'hC: it.exp = {30'd0, m_inc, m_alm};
            default: it.exp = 32'd0;
        endcase
        it.tag = tag;
        sb.push_back(it);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk);
        if (a[3:0] == 4'hC) begin m_inc = 0; m_alm = 0; end
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_stat_tick(input string tag);
        item_t it;
        @(negedge clk);
        it.exp = {30'd0, m_inc, m_alm};
        it.tag = tag;
        sb.push_back(it);
        bus_sel = 1; bus_wr = 0; bus_addr = A_STAT; slow_tick = 1;
        @(posedge clk);
        m_inc = 0; m_alm = 0;
        model_step();
        @(negedge clk);
        bus_sel = 0; slow_tick = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a[3:0] == 4'h0) begin
            m_mode = d;
            if (d[18]) begin
                m_vr = '0; m_pre = 0;
                m_div = (d[15:0] == 0) ? 32768 : int'(d[15:0]);
            end
        end else if (a[3:0] == 4'h4) begin
            m_ar = d[CW-1:0];
        end
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        slow_tick = 1;
        repeat (n) begin
            @(posedge clk);
            model_step();
        end
        @(negedge clk);
        slow_tick = 0;
    endtask

    task automatic chk_irq(input string tag);
        logic e;
        e = (m_inc && m_mode[17]) || (m_alm && m_mode[16]);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8 reset state
        chk_irq("R8 irq after reset");
        rd(A_MODE,  "R8 mode reset");
        rd(A_ALARM, "R8 alarm reset");
        rd(A_VALUE, "R8 value reset");
        rd(A_STAT,  "R8 status reset");
        // R1 decode: unmapped and aliasing
        rd(8'h02, "R1 unmapped 0x2");
        rd(8'h0D, "R1 unmapped 0xD");
        rd(8'h34, "R1 alias of alarm");
        // R2/R3/R4 divisor 4
        wr(A_MODE, 32'h0004_0004);
        rd(A_MODE, "R2 mode readback");
        tick(3);
        rd(A_VALUE, "R4 no step before divisor");
        rd(A_STAT,  "R4 status idle");
        tick(1);
        rd(A_VALUE, "R4 step at divisor");
        rd(A_STAT,  "R4 increment flag");
        rd(A_STAT,  "R7 flags cleared by read");
        // R9 non-writable registers
        wr(A_VALUE, 32'h55);
        wr(A_STAT, 32'h3);
        rd(A_VALUE, "R9 value not writable");
        rd(A_STAT,  "R9 status not writable");
        wr(A_ALARM, 32'h0000_00A5);
        rd(A_ALARM, "R9 alarm readback");
        // R5 alarm at alarm plus one, divisor 2
        wr(A_ALARM, 32'h2);
        wr(A_MODE, 32'h0004_0002);
        tick(4);
        rd(A_VALUE, "R5 value at alarm");
        rd(A_STAT,  "R5 no alarm on equality");
        tick(2);
        rd(A_STAT,  "R5 alarm at alarm plus one");
        // R6 increment enable only, divisor 3
        wr(A_MODE, 32'h0006_0003);
        rd(A_STAT, "R6 clear before");
        tick(2);
        chk_irq("R6 irq low before step");
        tick(1);
        chk_irq("R6 irq on increment");
        rd(A_STAT, "R7 status with irq");
        chk_irq("R7 irq dropped by read");
        // R6 alarm enable only, divisor 1
        wr(A_ALARM, 32'h1);
        wr(A_MODE, 32'h0005_0001);
        rd(A_STAT, "R6 clear before alarm");
        tick(1);
        chk_irq("R6 increment masked");
        tick(1);
        chk_irq("R6 irq on alarm");
        rd(A_STAT, "R6 alarm status");
        chk_irq("R7 irq dropped after alarm read");
        // R7 event on the read edge is kept
        wr(A_MODE, 32'h0004_0001);
        rd(A_STAT, "R7 clear before coincidence");
        rd_stat_tick("R7 read with coincident tick");
        rd(A_STAT, "R7 coincident event kept");
        // R10 and R5 wrap with alarm disabled
        wr(A_ALARM, 32'hFFFF_FFFF);
        wr(A_MODE, 32'h0004_0001);
        tick(255);
        rd(A_VALUE, "R10 value at all ones");
        rd(A_STAT,  "R10 status before wrap");
        tick(1);
        rd(A_VALUE, "R10 wrapped to zero");
        rd(A_STAT,  "R5 no alarm when alarm all ones");
        // R3 divisor zero acts as 32768
        wr(A_MODE, 32'h0004_0000);
        tick(32767);
        rd(A_VALUE, "R3 zero divisor no early step");
        tick(1);
        rd(A_VALUE, "R3 zero divisor step at 32768");
        drain();
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard residue actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule